// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

A 32-bit register bank that gathers interrupt causes and produces one interrupt line. Each interrupt source owns one bit index, and that index means the same source in every register of the bank. Hardware pulses on `hw_event` latch into the cause register. Software can force a cause through a write-only set register. A mask decides which latched causes reach the interrupt output. The mask can be written directly, or changed bit by bit through separate set and clear aliases, so no read-modify-write is needed.

A per-bit clear-mode register controls how each cause bit is cleared. With a 0, the bit is cleared by writing 1 to it. With a 1, the bit is cleared when a read returns it. The masked-cause register shows only the unmasked causes and uses the same clear rules as the cause register.

The register bus is a single-cycle interface. An access is accepted in every cycle in which `bus_sel` is high. Read data comes out combinationally in the same cycle, and side effects of the access take place at the next clock edge.

Top module: `icr_bank`

## Requirements
- R1: After a synchronous active-low reset, the cause register reads 0, the clear-mode register reads 0, the mask reads all ones, and `irq` is 0.
- R2: A 1 on `hw_event[i]` sets cause bit i at the next clock edge. If the same bit is also cleared in that cycle, by a write-one clear or by a clear-on-read, the bit stays set.
- R3: Writing to index 3 (cause set) sets every cause bit whose data bit is 1 and leaves bits with a 0 unchanged. A read of index 3 returns 0.
- R4: A clear-mode bit of 0 (index 0) makes the cause bit write-one-to-clear. Writing 1 to that bit at index 1 (cause) or index 2 (masked cause) clears it. A read does not clear it.
- R5: A clear-mode bit of 1 makes the cause bit clear-on-read. An accepted read of index 1 clears exactly the bits it returned as 1. Writes to index 1 or 2 do not affect that bit. Nothing is cleared while `bus_sel` is low.
- R6: A read of index 2 returns cause AND NOT mask. A clear-on-read through index 2 clears only the bits it returned as 1, so masked causes stay latched.
- R7: Index 4 (mask value) is read and written directly.
- R8: Writing 1 to a bit at index 5 sets that mask bit. Writing 1 to a bit at index 6 clears it. Zero bits leave the mask unchanged. Both indexes read 0.
- R9: `irq` is the OR of all masked-cause bits, registered, so it changes one clock after the cause or mask changes.
- R10: Index 7 is unused. It reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, accepted in the same cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Register word index (0..6 used) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| hw_event | input | 32 | Per-source cause pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
A behavioural reference model tracks the cause, clear-mode and mask state. On every clock the bench compares `irq` and any read data against that model.

The stimulus covers several patterns:
- Pure hardware events against software-forced causes, which separates the two set paths.
- The same bits cleared under write-one and under clear-on-read mode, which shows that the clear-mode bit really selects the mechanism.
- Clear-on-read through the masked view with some set bits masked, which tells "clears what was returned" apart from "clears all set bits".
- Event-and-clear collisions in the same cycle, and accesses to the unused index, which cover the priority rule and the decode boundary.

// File: rtl/icr_pkg.sv
// Package: shared register indexes and access strobes for the interrupt
// cause/mask bank. Assumes a 3-bit word index on the register bus.
package icr_pkg;

    localparam int unsigned IDX_W = 3;

    // Word index of each register; the order is decoded by software.
    typedef enum logic [IDX_W-1:0] {
        IDX_CTL    = 3'd0,
        IDX_CAUSE  = 3'd1,
        IDX_MASKED = 3'd2,
        IDX_CSET   = 3'd3,
        IDX_MVAL   = 3'd4,
        IDX_MSET   = 3'd5,
        IDX_MCLR   = 3'd6,
        IDX_NONE   = 3'd7
    } reg_idx_e;

    // One-hot style access strobes produced by the decoder.
    typedef struct packed {
        logic wr_ctl;
        logic wr_cause;
        logic wr_masked;
        logic wr_cset;
        logic wr_mval;
        logic wr_mset;
        logic wr_mclr;
        logic rd_cause;
        logic rd_masked;
    } strobe_t;

endpackage

// File: rtl/icr_decode.sv
// Module: icr_decode
// Turns one accepted bus access into per-register strobes.
// Assumes an access is accepted in every cycle that sel is high.
module icr_decode
    import icr_pkg::*;
(
    input  logic             sel,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    output strobe_t          stb
);

    // Decode the access type and register index into strobes.
    always_comb begin
        stb = '0;
        if (sel) begin
            case (reg_idx_e'(idx))
                IDX_CTL:    stb.wr_ctl    = wr;
                IDX_CAUSE:  begin
                    stb.wr_cause = wr;
                    stb.rd_cause = !wr;
                end
                IDX_MASKED: begin
                    stb.wr_masked = wr;
                    stb.rd_masked = !wr;
                end
                IDX_CSET:   stb.wr_cset   = wr;
                IDX_MVAL:   stb.wr_mval   = wr;
                IDX_MSET:   stb.wr_mset   = wr;
                IDX_MCLR:   stb.wr_mclr   = wr;
                default:    stb = '0;
            endcase
        end
    end

endmodule

// File: rtl/icr_cause_cell.sv
// Module: icr_cause_cell
// One interrupt source: its clear-mode bit and its latched cause bit.
// Assumes the mask bit comes from the mask register for the same index.
// Priority: any set (event or forced) beats any clear in the same cycle.
module icr_cause_cell
    import icr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t stb,
    input  logic    wdata_bit,
    input  logic    event_bit,
    input  logic    mask_bit,
    output logic    cause_q,
    output logic    ctl_q
);

    logic set_hit;
    logic w1c_hit;
    logic cor_hit;

    // Work out this cycle's set and clear requests for the bit.
    always_comb begin
        set_hit = event_bit | (stb.wr_cset & wdata_bit);
        w1c_hit = (stb.wr_cause | stb.wr_masked) & wdata_bit & !ctl_q;
        cor_hit = (stb.rd_cause | (stb.rd_masked & !mask_bit)) & ctl_q & cause_q;
    end

    // Hold the clear-mode bit; it is written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= 1'b0;
        else if (stb.wr_ctl)
            ctl_q <= wdata_bit;
    end

    // Latch the cause bit with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= 1'b0;
        else if (set_hit)
            cause_q <= 1'b1;
        else if (w1c_hit | cor_hit)
            cause_q <= 1'b0;
    end

endmodule

// File: rtl/icr_mask_reg.sv
// Module: icr_mask_reg
// Interrupt mask with direct, set-alias and clear-alias writes.
// Assumes at most one strobe is active per cycle (single-access bus).
module icr_mask_reg
    import icr_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  strobe_t          stb,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q
);

    logic [WIDTH-1:0] mask_d;

    // Pick the next mask value from the active alias.
    always_comb begin
        mask_d = mask_q;
        if (stb.wr_mval)
            mask_d = wdata;
        else if (stb.wr_mset)
            mask_d = mask_q | wdata;
        else if (stb.wr_mclr)
            mask_d = mask_q & ~wdata;
    end

    // Register the mask; reset leaves every source masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else
            mask_q <= mask_d;
    end

endmodule

// File: rtl/icr_read_mux.sv
// Module: icr_read_mux
// Read-data selection. Write-only and unused indexes return zero,
// and the output is zero when no read is in progress.
module icr_read_mux
    import icr_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] ctl,
    input  logic [WIDTH-1:0] cause,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] rdata
);

    // Select the readable register for the given index.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_idx_e'(idx))
                IDX_CTL:    rdata = ctl;
                IDX_CAUSE:  rdata = cause;
                IDX_MASKED: rdata = cause & ~mask;
                IDX_MVAL:   rdata = mask;
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/icr_bank.sv
// Module: icr_bank (top)
// Interrupt cause/mask register bank with per-bit clear mode and a
// registered interrupt output. Assumes a single-cycle register bus on
// which every access with sel high is accepted.
module icr_bank
    import icr_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] hw_event,
    output logic             irq
);

    strobe_t          stb;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] ctl_q;
    logic [WIDTH-1:0] mask_q;
    logic             irq_q;

    icr_decode u_decode (
        .sel (bus_sel),
        .wr  (bus_wr),
        .idx (bus_idx),
        .stb (stb)
    );

    icr_mask_reg #(.WIDTH(WIDTH)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (stb),
        .wdata  (bus_wdata),
        .mask_q (mask_q)
    );

    // One cause cell per interrupt source.
    for (genvar i = 0; i < WIDTH; i++) begin : g_src
        icr_cause_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb       (stb),
            .wdata_bit (bus_wdata[i]),
            .event_bit (hw_event[i]),
            .mask_bit  (mask_q[i]),
            .cause_q   (cause_q[i]),
            .ctl_q     (ctl_q[i])
        );
    end

    icr_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .rd_en (bus_sel & !bus_wr),
        .idx   (bus_idx),
        .ctl   (ctl_q),
        .cause (cause_q),
        .mask  (mask_q),
        .rdata (bus_rdata)
    );

    // Register the OR of all unmasked causes as the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(cause_q & ~mask_q);
    end

    assign irq = irq_q;

endmodule

// File: rtl/icr_bank_chk.sv
// Module: icr_bank_chk
// Temporal checks on the interrupt bank, attached to the top by bind.
module icr_bank_chk
    import icr_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [IDX_W-1:0] bus_idx,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] hw_event,
    input logic             irq,
    input logic [WIDTH-1:0] cause_q,
    input logic [WIDTH-1:0] ctl_q,
    input logic [WIDTH-1:0] mask_q
);

    logic rd_cause;
    logic wr_mset;
    logic wr_mclr;

    // Decode the accesses the properties care about.
    always_comb begin
        rd_cause = bus_sel && !bus_wr && (bus_idx == IDX_CAUSE);
        wr_mset  = bus_sel && bus_wr && (bus_idx == IDX_MSET);
        wr_mclr  = bus_sel && bus_wr && (bus_idx == IDX_MCLR);
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_event != '0) |=> ((cause_q & $past(hw_event)) == $past(hw_event)));

    assert_cor_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cause |=> ((cause_q & $past(ctl_q & bus_rdata & ~hw_event)) == '0));

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(bus_wdata)) == '0));

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & ~mask_q) != '0) |=> irq);

    assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & ~mask_q) == '0) |=> !irq);

endmodule

bind icr_bank icr_bank_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_event  (hw_event),
    .irq       (irq),
    .cause_q   (cause_q),
    .ctl_q     (ctl_q),
    .mask_q    (mask_q)
);

// File: tb/icr_bank_tb.sv
// Bench: behavioural reference model of the bank, compared every clock.
module icr_bank_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_idx = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_event = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Reference state.
    bit [31:0] m_cause, m_ctl, m_mask;
    bit        m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    icr_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_event  (hw_event),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] model_read(input bit [2:0] a);
        case (a)
            3'd0: return m_ctl;
            3'd1: return m_cause;
            3'd2: return m_cause & ~m_mask;
            3'd4: return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle: drive, check read data, clock, update model, check irq.
    task automatic cyc(input bit sel, input bit wr, input bit [2:0] a,
                       input bit [31:0] wd, input bit [31:0] ev, input string req);
        bit [31:0] set_v, clr_v, ret;
        bit        nxt_irq;
        bus_sel = sel; bus_wr = wr; bus_idx = a; bus_wdata = wd; hw_event = ev;
        #1;
        ret = (sel && !wr) ? model_read(a) : 32'h0;
        if (sel && !wr) check(req, bus_rdata, ret);
        nxt_irq = |(m_cause & ~m_mask);
        set_v = ev;
        clr_v = 32'h0;
        if (sel && wr && a == 3'd3) set_v |= wd;
        if (sel && wr && (a == 3'd1 || a == 3'd2)) clr_v |= wd & ~m_ctl;
        if (sel && !wr && (a == 3'd1 || a == 3'd2)) clr_v |= ret & m_ctl;
        @(posedge clk);
        m_cause = (m_cause & ~clr_v) | set_v;
        if (sel && wr) begin
            case (a)
                3'd0: m_ctl = wd;
                3'd4: m_mask = wd;
                3'd5: m_mask = m_mask | wd;
                3'd6: m_mask = m_mask & ~wd;
                default: ;
            endcase
        end
        m_irq = nxt_irq;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; hw_event = '0;
        check("R9", {31'h0, irq}, {31'h0, m_irq});
    endtask

    task automatic rd(input bit [2:0] a, input string req);
        cyc(1'b1, 1'b0, a, 32'h0, 32'h0, req);
    endtask

    task automatic wrr(input bit [2:0] a, input bit [31:0] d);
        cyc(1'b1, 1'b1, a, d, 32'h0, "wr");
    endtask

    task automatic idle(input bit [31:0] ev);
        cyc(1'b0, 1'b0, 3'd0, 32'h0, ev, "idle");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cause = '0; m_ctl = '0; m_mask = '1; m_irq = 1'b0;
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(3'd0, "R1 ctl"); rd(3'd1, "R1 cause"); rd(3'd4, "R1 mask"); rd(3'd2, "R1 masked");

        // R2: events latch; masked, so no irq
        idle(32'h0000_0011);
        rd(3'd1, "R2 event latch");
        // R7: direct mask write
        wrr(3'd4, 32'hFFFF_0000);
        rd(3'd4, "R7 mask readback");
        idle(32'h0); idle(32'h0);
        // R6: masked view
        rd(3'd2, "R6 masked view");
        // R4: write-one-to-clear via cause and masked, read does not clear
        wrr(3'd1, 32'h0000_0001);
        rd(3'd1, "R4 w1c cause");
        rd(3'd1, "R4 read no clear");
        wrr(3'd2, 32'h0000_0010);
        rd(3'd1, "R4 w1c masked");
        // R2: collision, event wins over W1C
        idle(32'h0000_0004);
        cyc(1'b1, 1'b1, 3'd1, 32'h0000_0004, 32'h0000_0004, "wr");
        rd(3'd1, "R2 event beats clear");
        wrr(3'd1, 32'h0000_0004);
        // R5: clear-on-read mode
        wrr(3'd0, 32'h0000_00F0);
        rd(3'd0, "R5 ctl readback");
        idle(32'h0000_00F0);
        wrr(3'd1, 32'h0000_00F0);
        rd(3'd1, "R5 write ignored");
        idle(32'h0); idle(32'h0);
        rd(3'd1, "R5 still set without access");
        rd(3'd1, "R5 cleared by read");
        idle(32'h0000_0020);
        cyc(1'b1, 1'b0, 3'd1, 32'h0, 32'h0000_0020, "R5 read with event");
        rd(3'd1, "R2 event beats cor");
        rd(3'd1, "R5 cleared after");
        // R6/R8: COR through masked view clears only unmasked bits
        wrr(3'd5, 32'h0000_0080);
        rd(3'd5, "R8 mset reads zero");
        idle(32'h0000_00C0);
        rd(3'd2, "R6 masked cor");
        rd(3'd1, "R6 masked bit kept");
        // R8: mask clear
        wrr(3'd6, 32'h00FF_0080);
        rd(3'd4, "R8 mask after clear");
        rd(3'd6, "R8 mclr reads zero");
        idle(32'h0);
        rd(3'd1, "R8 cause after unmask");
        // R3: forced causes
        wrr(3'd3, 32'h0300_0000);
        rd(3'd1, "R3 forced set");
        rd(3'd3, "R3 cset reads zero");
        idle(32'h0);
        // R10: unused index
        wrr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, "R10 unused reads zero");
        rd(3'd4, "R10 mask unchanged");
        rd(3'd1, "R10 cause unchanged");
        rd(3'd0, "R10 ctl unchanged");
        // Mask everything back: irq should drop
        wrr(3'd4, 32'hFFFF_FFFF);
        idle(32'h0); idle(32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule